// File: doc/BRIEF.md
# Halfword-Swapping DMA Address and Burst Stage

This stage sits between a peripheral with a 16-bit data path and a 32-bit memory port. For each transfer request it builds the memory address by ORing the peripheral's offset with a per-channel base value. It then issues one or more burst requests to memory. After each burst is acknowledged, it streams that burst's data from the peripheral side to the memory side, one halfword per handshake.

Each request can select swap mode. In swap mode, bit 0 is cleared in both the formed address and the byte count, the two bytes of every halfword are exchanged, and the transfer is split into bursts of at most `MAX_BURST` bytes. The address moves forward by each burst's length. Without swap mode, the data, address and byte count pass through untouched as a single burst.

The stage accepts a new request only while it is idle. It raises a one-cycle completion pulse once the last halfword of the last burst has been handed on. A request whose byte count is zero after rounding finishes at once, without touching memory.

Top module: `swapdma_top`

## Requirements
- R1: The first burst address equals `reqOffset | baseAddr`, a bitwise OR with no carry. It is not the arithmetic sum.
- R2: When `reqSwap` is 1, bit 0 of the formed address and bit 0 of the byte count are both forced to 0 before any burst is issued.
- R3: When `reqSwap` is 1, each data halfword leaves with its bytes exchanged: `outData = {inData[7:0], inData[15:8]}`.
- R4: When `reqSwap` is 0, data passes unchanged, and the whole unmodified byte count is issued as one burst at the unmodified address.
- R5: When `reqSwap` is 1, the transfer is split into bursts of `min(remaining, MAX_BURST)` bytes (default 64). Each burst address is the previous address plus the previous burst length.
- R6: A request whose byte count is 0 after rounding produces no burst request. It completes with `done` high in the cycle after the request is accepted.
- R7: `burstValid` stays high with stable `burstAddr` and `burstLen` until `burstAck`. The next burst is never requested before the current one is acknowledged and its data has been moved.
- R8: `done` is a single-cycle pulse, issued one cycle after the final data handshake. `reqReady` is high only while the stage is idle.
- R9: During a burst of L bytes, exactly ceil(L/2) halfwords move. A halfword moves on a cycle where `inValid` and `outReady` are both high. In that phase, `inReady` follows `outReady` and `outValid` follows `inValid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Transfer request present |
| reqReady | output | 1 | Stage idle, request taken |
| reqOffset | input | AW | Peripheral offset |
| reqLen | input | LW | Transfer byte count |
| reqSwap | input | 1 | Select halfword byte swap mode |
| baseAddr | input | AW | Channel base value ORed into the address |
| inValid | input | 1 | Peripheral halfword present |
| inReady | output | 1 | Peripheral halfword taken |
| inData | input | DW | Peripheral halfword |
| burstValid | output | 1 | Memory burst request |
| burstAck | input | 1 | Memory burst request acknowledged |
| burstAddr | output | AW | Burst start address |
| burstLen | output | LW | Burst byte count |
| outValid | output | 1 | Memory-side halfword present |
| outReady | input | 1 | Memory side accepts halfword |
| outData | output | DW | Processed halfword |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench uses an offset and base whose bits overlap. A design that adds instead of ORing gives a carried address. It sends odd offsets and odd counts in swap mode, where a stage that skips the rounding emits an odd address or one halfword too many. A 150-byte swapped transfer must come out as bursts of 64, 64 and 22 bytes at stepped addresses, while a 200-byte unswapped transfer must stay whole. One-byte and zero-byte requests must raise only `done`. Memory-side back-pressure and delayed acknowledges would expose a stage that drops or repeats halfwords, or moves on before a burst is acknowledged.

// File: rtl/swapdma_pkg.sv
package swapdma_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_DATA,
    ST_DONE
  } dmaState_t;

  typedef struct packed {
    logic load;        // capture a new request
    logic startBurst;  // burst acknowledged, load halfword counter
    logic beatStep;    // one halfword moved
    logic advance;     // burst finished, step address and remaining count
  } dpCtl_t;

endpackage

// File: rtl/swapdma_datapath.sv
module swapdma_datapath
  import swapdma_pkg::*;
#(
  parameter int AW        = 32,
  parameter int LW        = 16,
  parameter int DW        = 16,
  parameter int MAX_BURST = 64
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpCtl_t        ctl,
  input  logic [AW-1:0] reqOffset,
  input  logic [LW-1:0] reqLen,
  input  logic          reqSwap,
  input  logic [AW-1:0] baseAddr,
  input  logic [DW-1:0] inData,
  output logic [DW-1:0] outData,
  output logic [AW-1:0] burstAddr,
  output logic [LW-1:0] burstLen,
  output logic          lenZeroIn,
  output logic          lastBeat,
  output logic          lastBurst
);
  localparam int NB = DW / 8;
  localparam logic [LW-1:0] MAX_L = LW'(MAX_BURST);

  logic [AW-1:0] addrR;
  logic [LW-1:0] remR;
  logic [LW-1:0] beatsR;
  logic          swapR;
  logic [AW-1:0] formedAddr;
  logic [LW-1:0] formedLen;
  logic [LW-1:0] curLen;
  logic [LW:0]   beatsCalc;
  logic [DW-1:0] swapped;

  // Request shaping: OR the offset into the base, then round in swap mode.
  always_comb begin
    formedAddr = reqOffset | baseAddr;
    formedLen  = reqLen;
    if (reqSwap) begin
      formedAddr[0] = 1'b0;
      formedLen[0]  = 1'b0;
    end
  end

  assign lenZeroIn = (formedLen == '0);

  // Burst sizing: capped only in swap mode.
  assign curLen    = (swapR && (remR > MAX_L)) ? MAX_L : remR;
  assign beatsCalc = ({1'b0, curLen} + 1'b1) >> 1;
  assign lastBurst = (remR == curLen);
  assign lastBeat  = (beatsR == LW'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrR  <= '0;
      remR   <= '0;
      beatsR <= '0;
      swapR  <= 1'b0;
    end else begin
      if (ctl.load) begin
        addrR <= formedAddr;
        remR  <= formedLen;
        swapR <= reqSwap;
      end else if (ctl.advance) begin
        addrR <= addrR + AW'(curLen);
        remR  <= remR - curLen;
      end
      if (ctl.startBurst)    beatsR <= beatsCalc[LW-1:0];
      else if (ctl.beatStep) beatsR <= beatsR - 1'b1;
    end
  end

  // Byte lane reversal inside each halfword.
  for (genvar b = 0; b < NB; b++) begin : g_lane
    assign swapped[b*8 +: 8] = inData[(b ^ 1)*8 +: 8];
  end

  assign outData   = swapR ? swapped : inData;
  assign burstAddr = addrR;
  assign burstLen  = curLen;

  assert_addr_even_R2: assert property (@(posedge clk) disable iff (!rstN)
    (swapR && remR != '0) |-> (addrR[0] == 1'b0 && remR[0] == 1'b0));

  assert_burst_cap_R5: assert property (@(posedge clk) disable iff (!rstN)
    swapR |-> (curLen <= MAX_L));

endmodule

// File: rtl/swapdma_ctrl.sv
module swapdma_ctrl
  import swapdma_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   reqValid,
  input  logic   burstAck,
  input  logic   inValid,
  input  logic   outReady,
  input  logic   lenZeroIn,
  input  logic   lastBeat,
  input  logic   lastBurst,
  output dpCtl_t ctl,
  output logic   reqReady,
  output logic   burstValid,
  output logic   inReady,
  output logic   outValid,
  output logic   done
);
  dmaState_t state, nextState;
  logic      beatFire;

  assign reqReady   = (state == ST_IDLE);
  assign burstValid = (state == ST_REQ);
  assign inReady    = (state == ST_DATA) && outReady;
  assign outValid   = (state == ST_DATA) && inValid;
  assign done       = (state == ST_DONE);
  assign beatFire   = (state == ST_DATA) && inValid && outReady;

  always_comb begin
    nextState      = state;
    ctl            = '0;
    ctl.load       = reqReady && reqValid;
    ctl.startBurst = burstValid && burstAck;
    ctl.beatStep   = beatFire;
    ctl.advance    = beatFire && lastBeat;
    unique case (state)
      ST_IDLE: if (reqValid) nextState = lenZeroIn ? ST_DONE : ST_REQ;
      ST_REQ:  if (burstAck) nextState = ST_DATA;
      ST_DATA: if (beatFire && lastBeat) nextState = lastBurst ? ST_DONE : ST_REQ;
      ST_DONE: nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_ready_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    (reqReady && reqValid) |=> !reqReady);

  assert_no_data_in_req_R9: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !burstValid);

endmodule

// File: rtl/swapdma_top.sv
module swapdma_top
  import swapdma_pkg::*;
#(
  parameter int AW        = 32,
  parameter int LW        = 16,
  parameter int DW        = 16,
  parameter int MAX_BURST = 64
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  output logic          reqReady,
  input  logic [AW-1:0] reqOffset,
  input  logic [LW-1:0] reqLen,
  input  logic          reqSwap,
  input  logic [AW-1:0] baseAddr,
  input  logic          inValid,
  output logic          inReady,
  input  logic [DW-1:0] inData,
  output logic          burstValid,
  input  logic          burstAck,
  output logic [AW-1:0] burstAddr,
  output logic [LW-1:0] burstLen,
  output logic          outValid,
  input  logic          outReady,
  output logic [DW-1:0] outData,
  output logic          done
);
  dpCtl_t ctl;
  logic   lenZeroIn, lastBeat, lastBurst;

  swapdma_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .burstAck(burstAck),
    .inValid(inValid), .outReady(outReady), .lenZeroIn(lenZeroIn),
    .lastBeat(lastBeat), .lastBurst(lastBurst), .ctl(ctl),
    .reqReady(reqReady), .burstValid(burstValid), .inReady(inReady),
    .outValid(outValid), .done(done)
  );

  swapdma_datapath #(.AW(AW), .LW(LW), .DW(DW), .MAX_BURST(MAX_BURST)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reqOffset(reqOffset), .reqLen(reqLen),
    .reqSwap(reqSwap), .baseAddr(baseAddr), .inData(inData), .outData(outData),
    .burstAddr(burstAddr), .burstLen(burstLen), .lenZeroIn(lenZeroIn),
    .lastBeat(lastBeat), .lastBurst(lastBurst)
  );

  assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (burstValid && !burstAck) |=> (burstValid && $stable(burstAddr) && $stable(burstLen)));

  assert_ready_follow_R9: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> outReady);

endmodule

// File: tb/swapdma_top_test.sv
module swapdma_top_test;
  localparam int AW = 32;
  localparam int LW = 16;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic          reqReady;
  logic [AW-1:0] reqOffset = '0;
  logic [LW-1:0] reqLen = '0;
  logic          reqSwap = 1'b0;
  logic [AW-1:0] baseAddr = '0;
  logic          inValid = 1'b0;
  logic          inReady;
  logic [DW-1:0] inData = '0;
  logic          burstValid;
  logic          burstAck = 1'b0;
  logic [AW-1:0] burstAddr;
  logic [LW-1:0] burstLen;
  logic          outValid;
  logic          outReady = 1'b0;
  logic [DW-1:0] outData;
  logic          done;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [DW-1:0]     srcQ[$];
  logic [DW-1:0]     expQ[$];
  logic [AW+LW-1:0]  burstQ[$];

  always #10 clk = ~clk;

  swapdma_top uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqOffset(reqOffset), .reqLen(reqLen), .reqSwap(reqSwap), .baseAddr(baseAddr),
    .inValid(inValid), .inReady(inReady), .inData(inData),
    .burstValid(burstValid), .burstAck(burstAck), .burstAddr(burstAddr),
    .burstLen(burstLen), .outValid(outValid), .outReady(outReady),
    .outData(outData), .done(done)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Monitor: feeds halfwords, answers bursts, compares against scoreboards.
  always @(negedge clk) begin
    cyc++;
    inValid  = (srcQ.size() > 0);
    inData   = (srcQ.size() > 0) ? srcQ[0] : '0;
    outReady = (cyc % 5) != 3;
    #1;
    if (burstValid && !burstAck && (cyc % 3 != 0)) begin
      if (burstQ.size() == 0) begin
        check(1'b0, "R6 unexpected burst", {burstAddr, burstLen}, 0);
      end else begin
        logic [AW+LW-1:0] e;
        e = burstQ.pop_front();
        check({burstAddr, burstLen} == e, "R1/R2/R5 burst addr+len", {burstAddr, burstLen}, e);
      end
      burstAck = 1'b1;
    end else begin
      burstAck = 1'b0;
    end
    if (outValid && outReady) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R9 extra halfword", outData, 0);
      end else begin
        logic [DW-1:0] e;
        e = expQ.pop_front();
        check(outData == e, "R3/R4 data", outData, e);
      end
      if (srcQ.size() > 0) void'(srcQ.pop_front());
    end
  end

  task automatic xfer(input logic [AW-1:0] off, input logic [AW-1:0] base,
                      input int len, input bit sw, input int nBursts);
    int eff;
    int rem;
    int beats;
    logic [AW-1:0] a;
    logic [DW-1:0] w;
    int waitCnt;
    bit seen;
    eff = sw ? (len & ~1) : len;
    a   = off | base;
    if (sw) a[0] = 1'b0;
    rem = eff;
    while (rem > 0) begin
      int bl;
      bl = (sw && rem > 64) ? 64 : rem;
      burstQ.push_back({a, LW'(bl)});
      a   = a + AW'(bl);
      rem = rem - bl;
    end
    check(burstQ.size() == nBursts, "R5 plan", burstQ.size(), nBursts);
    beats = 0;
    rem = eff;
    while (rem > 0) begin
      int bl;
      bl = (sw && rem > 64) ? 64 : rem;
      beats += (bl + 1) / 2;
      rem -= bl;
    end
    for (int i = 0; i < beats; i++) begin
      w = DW'((len * 37 + i * 4099 + 16'h1a2b) & 16'hffff);
      srcQ.push_back(w);
      expQ.push_back(sw ? {w[7:0], w[15:8]} : w);
    end
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqOffset = off; baseAddr = base; reqLen = LW'(len); reqSwap = sw; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    // R8: busy after accept; R6: zero-length reaches done right here
    check(!reqReady, "R8 ready low when busy", reqReady, 0);
    if (eff == 0) check(done == 1'b1, "R6 immediate done", done, 1);
    seen = done;
    waitCnt = 0;
    while (!seen && waitCnt < 5000) begin
      @(negedge clk);
      waitCnt++;
      seen = done;
    end
    check(seen, "R8 done seen", seen, 1);
    check(burstQ.size() == 0 && expQ.size() == 0, "R9 all bursts and halfwords",
          burstQ.size() + expQ.size(), 0);
    @(negedge clk);
    check(!done, "R8 done single cycle", done, 0);
    check(reqReady, "R8 idle after done", reqReady, 1);
    srcQ.delete(); expQ.delete(); burstQ.delete();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(reqReady && !burstValid && !outValid && !done, "R8 reset state",
          {reqReady, burstValid, outValid, done}, 4'b1000);
    rstN = 1'b1;
    @(negedge clk);
    // R1: OR not add, R4 passthrough with odd length
    xfer(32'h0000_0013, 32'h1000_0011, 5, 1'b0, 1);
    // R2/R3: odd offset and length rounded in swap mode
    xfer(32'h0000_0103, 32'h0020_0000, 9, 1'b1, 1);
    // R5: split 64/64/22 with stepped addresses
    xfer(32'h0000_0000, 32'h0000_4000, 150, 1'b1, 3);
    // R6: one byte in swap mode rounds to zero
    xfer(32'h0000_0001, 32'h0000_8000, 1, 1'b1, 0);
    // R6: zero-length passthrough
    xfer(32'h0000_0020, 32'h0000_8000, 0, 1'b0, 0);
    // R4: long passthrough stays one burst
    xfer(32'h0000_0040, 32'h0003_0000, 200, 1'b0, 1);
    // R5/R7: exactly one full burst then a short one
    xfer(32'h0000_0006, 32'h0001_0000, 66, 1'b1, 2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule